// File: doc/BRIEF.md
# Two-wire write-only configuration receiver

This block takes configuration from a host over two lines, a serial clock and an open-drain data line. Both lines are brought into the system clock domain through flop synchronizers. Start and stop conditions and clock edges are then found by comparing successive synchronized samples. A transfer is a fixed frame of eight-bit bytes. The first byte is a target address, and the receiver answers only the one value it is built for. The next two bytes are filler that the host must send to keep the frame aligned, and their values do not matter. The bytes after that load a bank of seven configuration registers, first to last.

The receiver only listens. It never drives register contents back to the host. The one thing it drives is an acknowledge: it pulls the data line low during the ninth clock of each byte, and it does this only while the frame is addressed to it. The registers hold built-in defaults from reset, so the logic that reads them works even if no write ever arrives. Each register takes its new value as soon as its byte has been clocked in, and a one-cycle strobe marks which register changed. A stop in the middle of a frame leaves every byte already written in place.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, register k (bits [8k+7:8k] of `reg_o`) equals byte k of the `RESET_VALUES` parameter, `reg_wr_o` is all zero and `sda_pull_o` is 0.
- R2: When the first byte after a start is 8'hD2 (binary 11010010, received most significant bit first on rising serial clock edges), `sda_pull_o` is 1 while the serial clock is high on the ninth clock of that byte and of every later byte in the frame.
- R3: When the first byte after a start is any other value, `sda_pull_o` stays 0, no register changes and `reg_wr_o` stays zero until the next start.
- R4: In an addressed frame, the second and third bytes change no register and raise no strobe, whatever their values.
- R5: In an addressed frame, the fourth through tenth bytes are stored exactly as received (reserved bits included) into registers 0 through 6 in order.
- R6: Each register write raises bit k of `reg_wr_o` for exactly one system clock cycle, in the same cycle that register k takes its new value, and no register value changes without its strobe.
- R7: A stop before the tenth byte keeps the registers already written and leaves the rest at their previous values.
- R8: Bytes after the tenth in an addressed frame are acknowledged but change no register.
- R9: A start at any point, including in the middle of a frame with no stop, makes the next byte the address byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line from the host |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| reg_o | output | 8*NUM_DATA | Configuration registers, register k at bits [8k+7:8k] |
| reg_wr_o | output | NUM_DATA | One-cycle write strobe, bit k for register k |

## Verification
The host may move the data line in the very system cycle in which it drops the clock. After synchronization the receiver then sees a falling clock and a changed data level together, and a careless detector would take that for a start or a stop. In each bit the bench waits a random 0 to 2 cycles after the clock falls before it changes the data line, so many transitions land in the same cycle as the clock fall. It judges the outcome by the final register contents, the per-register strobe counts and the acknowledge pattern, all compared with a model of the frame. An unwanted start or stop would show up as lost alignment or a missing write.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] cfg_byte_t;

  // Role of the byte currently being shifted in
  typedef enum logic [1:0] {
    SLOT_ADDR,
    SLOT_SKIP,
    SLOT_DATA,
    SLOT_SPILL
  } slot_t;
endpackage

// File: rtl/cfgrx_line_sync.sv
module cfgrx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic scl_s;
  logic scl_d;
  logic sda_d;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // The clock must be high in both samples, so a data change that arrives
  // together with a clock fall is never taken as a start or a stop.
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfgrx_frame_fsm.sv
module cfgrx_frame_fsm
  import cfgrx_pkg::*;
#(
  parameter int        NUM_DATA    = 7,
  parameter int        SKIP_BYTES  = 2,
  parameter cfg_byte_t TARGET_ADDR = 8'hD2,
  parameter int        IDX_W       = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_p,
  input  logic             stop_p,
  output logic             ack_o,
  output logic             addr_ok_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output cfg_byte_t        wr_data_o
);
  localparam int DATA_FIRST = 1 + SKIP_BYTES;
  localparam int POS_LAST   = DATA_FIRST + NUM_DATA;
  localparam int POS_W      = $clog2(POS_LAST + 1);
  localparam int CNT_W      = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

  logic              active;
  logic              addr_ok;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [POS_W-1:0]  byte_pos;
  logic              ack_q;
  slot_t             slot;
  cfg_byte_t         next_byte;
  logic [POS_W-1:0]  data_off;

  always_comb begin
    if (byte_pos == '0)                           slot = SLOT_ADDR;
    else if (byte_pos < POS_W'(DATA_FIRST))       slot = SLOT_SKIP;
    else if (byte_pos < POS_W'(POS_LAST))         slot = SLOT_DATA;
    else                                          slot = SLOT_SPILL;
  end

  assign next_byte = {shreg, sda_s};
  assign data_off  = byte_pos - POS_W'(DATA_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      addr_ok   <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_pos  <= '0;
      ack_q     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_p) begin
        active   <= 1'b1;
        addr_ok  <= 1'b0;
        bit_cnt  <= '0;
        byte_pos <= '0;
        ack_q    <= 1'b0;
      end else if (stop_p) begin
        active  <= 1'b0;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bit_cnt == ACK_SLOT) begin
            bit_cnt <= '0;
            if (slot != SLOT_SPILL) byte_pos <= byte_pos + 1'b1;
          end else begin
            shreg   <= next_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (slot == SLOT_ADDR) begin
                addr_ok <= (next_byte == TARGET_ADDR);
              end else if (slot == SLOT_DATA && addr_ok) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= data_off[IDX_W-1:0];
                wr_data_o <= next_byte;
              end
            end
          end
        end else if (scl_fall) begin
          // Pull during the ninth clock, release on the fall that ends it
          ack_q <= (bit_cnt == ACK_SLOT) && addr_ok;
        end
      end
    end
  end

  assign ack_o     = ack_q;
  assign addr_ok_o = addr_ok;
endmodule

// File: rtl/cfgrx_reg_bank.sv
module cfgrx_reg_bank
  import cfgrx_pkg::*;
#(
  parameter int                       NUM_DATA     = 7,
  parameter logic [NUM_DATA*8-1:0]    RESET_VALUES = '0,
  parameter int                       IDX_W        = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  cfg_byte_t                  wr_data,
  output logic [NUM_DATA*BYTE_W-1:0] reg_flat,
  output logic [NUM_DATA-1:0]        strobe
);
  for (genvar k = 0; k < NUM_DATA; k++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        reg_flat[k*BYTE_W +: BYTE_W] <= RESET_VALUES[k*BYTE_W +: BYTE_W];
        strobe[k]                    <= 1'b0;
      end else begin
        strobe[k] <= hit;
        if (hit) reg_flat[k*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfgrx_pkg::*;
#(
  parameter int                    NUM_DATA     = 7,
  parameter int                    SKIP_BYTES   = 2,
  parameter int                    SYNC_STAGES  = 2,
  parameter logic [7:0]            TARGET_ADDR  = 8'hD2,
  parameter logic [NUM_DATA*8-1:0] RESET_VALUES = 56'h0F5A00FFC3817E
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_DATA*8-1:0] reg_o,
  output logic [NUM_DATA-1:0]   reg_wr_o
);
  localparam int IDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;

  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_p;
  logic             stop_p;
  logic             addr_ok;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  cfg_byte_t        wr_data;

  cfgrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  cfgrx_frame_fsm #(
    .NUM_DATA    (NUM_DATA),
    .SKIP_BYTES  (SKIP_BYTES),
    .TARGET_ADDR (TARGET_ADDR),
    .IDX_W       (IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .ack_o     (sda_pull_o),
    .addr_ok_o (addr_ok),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data)
  );

  cfgrx_reg_bank #(
    .NUM_DATA     (NUM_DATA),
    .RESET_VALUES (RESET_VALUES),
    .IDX_W        (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .reg_flat (reg_o),
    .strobe   (reg_wr_o)
  );
endmodule

// File: rtl/cfgrx_checker.sv
module cfgrx_checker #(
  parameter int NUM_DATA = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_pull_o,
  input logic [NUM_DATA*8-1:0] reg_o,
  input logic [NUM_DATA-1:0]   reg_wr_o,
  input logic                  addr_ok
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_wr_o)); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_o != '0) |=> (reg_wr_o == '0)); // R6

  AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_o) |-> (reg_wr_o != '0)); // R6

  AST_NO_ACK_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
    !addr_ok |-> !sda_pull_o); // R3

  AST_NO_WRITE_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
    !addr_ok |-> (reg_wr_o == '0)); // R3

  AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i); // R2
endmodule

bind cfg_serial_rx cfgrx_checker #(.NUM_DATA(NUM_DATA)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .reg_o      (reg_o),
  .reg_wr_o   (reg_wr_o),
  .addr_ok    (addr_ok)
);

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;
  localparam int ND = 7;
  localparam int Q  = 8;
  localparam logic [7:0]      ADDR = 8'hD2;
  localparam logic [ND*8-1:0] DEFV = 56'h0F5A00FFC3817E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [ND*8-1:0] reg_o;
  logic [ND-1:0]   strb;

  assign sda_line = sda_h & ~sda_pull;

  cfg_serial_rx dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_h),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .reg_o      (reg_o),
    .reg_wr_o   (strb)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_reg [ND];
  int exp_cnt [ND];
  int strb_cnt [ND];
  int mon_err = 0;
  logic [7:0] fdata [12];
  logic [ND*8-1:0] prev_reg;
  logic [ND-1:0]   prev_strb;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [ND*8-1:0] exp_flat();
    logic [ND*8-1:0] v;
    for (int k = 0; k < ND; k++) v[k*8 +: 8] = exp_reg[k];
    return v;
  endfunction

  // Strobe monitor (R6): value changes need a strobe, strobes last one cycle
  initial begin
    for (int k = 0; k < ND; k++) strb_cnt[k] = 0;
  end
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_o != prev_reg && strb == '0) mon_err++;
      if (!$onehot0(strb)) mon_err++;
      if (strb != '0 && prev_strb != '0) mon_err++;
      for (int k = 0; k < ND; k++) if (strb[k]) strb_cnt[k]++;
    end
    prev_reg  = reg_o;
    prev_strb = strb;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wait_n(Q);
    scl_h = 1'b1; wait_n(Q);
    sda_h = 1'b0; wait_n(Q);
    scl_h = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wait_n(Q);
    scl_h = 1'b1; wait_n(Q);
    sda_h = 1'b1; wait_n(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wait_n($urandom_range(2, 0));
      sda_h = b[i]; wait_n(Q);
      scl_h = 1'b1; wait_n(Q);
      scl_h = 1'b0;
    end
    sda_h = 1'b1; wait_n(Q);
    scl_h = 1'b1; wait_n(Q / 2);
    acked = sda_pull;
    wait_n(Q / 2);
    scl_h = 1'b0; wait_n(2);
  endtask

  task automatic fill_rand();
    for (int j = 0; j < 12; j++) fdata[j] = 8'($urandom);
  endtask

  // nb: bytes sent after the address (filler bytes first, then data)
  task automatic run_frame(input logic [7:0] addr, input int nb,
                           input bit end_stop, input string req);
    bit match;
    bit a;
    int ack_bad;
    ack_bad = 0;
    match = (addr == ADDR);
    bus_start();
    send_byte(addr, a);
    if (a != match) ack_bad++;
    for (int j = 0; j < nb; j++) begin
      send_byte(fdata[j], a);
      if (a != match) ack_bad++;
      if (match && j >= 2 && j - 2 < ND) begin
        exp_reg[j-2] = fdata[j];
        exp_cnt[j-2]++;
      end
    end
    if (end_stop) bus_stop();
    wait_n(4 * Q);
    chk(reg_o == exp_flat(), req, "registers", 64'(reg_o), 64'(exp_flat()));
    chk(ack_bad == 0, match ? "R2" : "R3", "ack mismatches", 64'(ack_bad), 64'd0);
    begin
      int bad_k;
      bad_k = -1;
      for (int k = ND - 1; k >= 0; k--) if (strb_cnt[k] != exp_cnt[k]) bad_k = k;
      if (bad_k < 0) chk(1'b1, "R6", "strobe counts", 64'd0, 64'd0);
      else chk(1'b0, "R6", "strobe count", 64'(strb_cnt[bad_k]), 64'(exp_cnt[bad_k]));
    end
  endtask

  initial begin
    void'($urandom(32'd20511));
    for (int k = 0; k < ND; k++) begin
      exp_reg[k] = DEFV[k*8 +: 8];
      exp_cnt[k] = 0;
    end
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    // R1 reset state
    chk(reg_o == DEFV, "R1", "reset registers", 64'(reg_o), 64'(DEFV));
    chk(strb == '0, "R1", "reset strobe", 64'(strb), 64'd0);
    chk(sda_pull == 1'b0, "R1", "reset pull", 64'(sda_pull), 64'd0);

    // R5 full addressed frame, reserved bits written as ones and zeros
    fill_rand();
    fdata[2] = 8'hFF; fdata[3] = 8'h00;
    run_frame(ADDR, 9, 1'b1, "R5");

    // R3 wrong addresses, one bit off at each end
    fill_rand();
    run_frame(8'hD3, 9, 1'b1, "R3");
    fill_rand();
    run_frame(8'h52, 9, 1'b1, "R3");

    // R4 filler bytes only
    fill_rand();
    fdata[0] = 8'hD2; fdata[1] = 8'hFF;
    run_frame(ADDR, 2, 1'b1, "R4");

    // R7 stop after two data bytes
    fill_rand();
    run_frame(ADDR, 4, 1'b1, "R7");

    // R8 two extra bytes past the last register
    fill_rand();
    run_frame(ADDR, 11, 1'b1, "R8");

    // R9 repeated start mid-frame, then wrong address, then addressed again
    fill_rand();
    run_frame(ADDR, 3, 1'b0, "R9");
    fill_rand();
    run_frame(8'h00, 9, 1'b0, "R9");
    fill_rand();
    run_frame(ADDR, 5, 1'b0, "R9");
    fill_rand();
    run_frame(ADDR, 9, 1'b1, "R9");

    // Random frames (R5)
    for (int n = 0; n < 20; n++) begin
      logic [7:0] ad;
      fill_rand();
      ad = ($urandom_range(1, 0) == 1) ? ADDR : 8'($urandom);
      run_frame(ad, $urandom_range(11, 0), ($urandom_range(3, 0) != 0), "R5");
    end

    chk(mon_err == 0, "R6", "strobe monitor errors", 64'(mon_err), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule